// File: doc/BRIEF.md
# Flash Write Status Byte Generator

This block forms the byte that a flash device returns on a read while an internal program or erase is running, is held in suspend, or is still collecting sector selections before the erase starts. A command decoder supplies the operation state (program busy, erase busy, erase collection window open, erase suspended), the latched program byte and the mask of sectors picked for erase. A timing monitor supplies a flag that says the internal pulse limit was overrun. The block either builds a status byte from these inputs or passes the array byte through unchanged.

The status byte carries five meaningful fields. Bit 7 is a polling bit that shows the complement of the byte being programmed, or erase progress. Bit 6 is a toggle bit that covers all addresses. Bit 2 is a second toggle bit that covers only the erase-selected sectors. Bit 3 tells the collection window apart from the running erase. Bit 5 is a sticky overrun flag. Both toggle bits advance on the rising edge of the read strobe. A program or erase aimed only at protected sectors shows busy status for a fixed number of clock cycles, set by a parameter, and then reads return array data again.

Top module: `flash_status_gen`

## Requirements
- R1: When no program, erase, collection window, suspend or protected interval is active, `rd_data` equals `array_data`. This also holds in suspend for addresses outside the selected sectors.
- R2: While a program is active (`prog_busy`, or the protected-program interval), bit 7 of `rd_data` is the inverse of `prog_datum[7]`. After the program ends, reads return `array_data`.
- R3: While an erase or the collection window is active and no program is active, bit 7 reads 0. In suspend, a read inside a selected sector gives bit 7 = 1.
- R4: Both toggle bits are 0 after reset. Bit 6 inverts after every read-strobe rising edge seen while a program, erase or collection window is active, at any address. In suspend with no program active, bit 6 holds its value.
- R5: Bit 2 inverts after a read-strobe rising edge at an address in a selected sector, while an erase, collection window or suspend is active and no program is active. Reads at other sectors leave it unchanged. The sector index is `rd_addr[AW-1 -: log2(NSEC)]`, and sector s is selected when `sector_mask[s]` is 1.
- R6: Bit 3 reads 0 while the collection window is open. It reads 1 while the erase runs (`erase_busy` or the protected-erase interval). It reads 0 in program and suspend status.
- R7: Bit 5 becomes 1 on the clock after `limit_exceeded` is high. It stays 1 until a cycle with `reset_cmd` high and `limit_exceeded` low, and it shows in every status byte.
- R8: A `prot_prog_start` pulse shows program status for exactly `PROT_PROG_CYC` clock cycles after the edge that samples it. Array data returns after that.
- R9: A `prot_erase_start` pulse shows erase status (bit 3 = 1) for exactly `PROT_ERASE_CYC` cycles after the edge that samples it.
- R10: Program status takes precedence over erase and suspend status at every address, including selected sectors during suspend.
- R11: In every status byte, bits 4, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_stb | input | 1 | Read strobe; a rising edge advances the toggle bits |
| rd_addr | input | AW | Read byte address |
| array_data | input | 8 | Byte read from the array |
| prog_busy | input | 1 | Program algorithm running |
| erase_busy | input | 1 | Erase algorithm running |
| erase_window | input | 1 | Sector collection window open before the erase |
| erase_susp | input | 1 | Erase suspended |
| prog_datum | input | 8 | Latched byte being programmed |
| sector_mask | input | NSEC | Sectors selected for erase |
| limit_exceeded | input | 1 | Internal pulse limit overrun |
| reset_cmd | input | 1 | Reset command accepted; clears the overrun flag |
| prot_prog_start | input | 1 | Program aimed at a protected sector |
| prot_erase_start | input | 1 | Erase in which every selected sector is protected |
| rd_data | output | 8 | Status byte or array byte |

## Verification
Two different program bytes, one with bit 7 set and one with it clear, show that the polling bit follows the datum and is not a fixed busy level. Reads inside and outside the selected sector, made during the window, the erase and the suspend, separate the toggle that covers all addresses from the toggle limited to the selected sectors. The same reads separate the window from the running erase through bit 3. A program started during suspend and the two protected-target intervals, sampled one cycle before and one cycle at the end of each interval, check the precedence of program status and the exact interval lengths.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef struct packed {
    logic       dpoll;      // bit 7
    logic       tog_all;    // bit 6
    logic       fail;       // bit 5
    logic       rsv4;       // bit 4
    logic       erase_tmr;  // bit 3
    logic       tog_sec;    // bit 2
    logic [1:0] rsv;        // bits 1:0
  } stat_byte_t;

  typedef enum logic [1:0] {
    VIEW_ARRAY,
    VIEW_PROG,
    VIEW_ERASE,
    VIEW_SUSP
  } view_e;

endpackage

// File: rtl/fsg_rst_sync.sv
module fsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic adv_all,
  input  logic adv_sec,
  output logic stb_rise,
  output logic tog_all,
  output logic tog_sec
);
  logic stb_q;
  logic tog_all_d, tog_sec_d;

  assign stb_rise = rd_stb & ~stb_q;

  always_comb begin
    tog_all_d = tog_all;
    tog_sec_d = tog_sec;
    if (stb_rise && adv_all) tog_all_d = ~tog_all;
    if (stb_rise && adv_sec) tog_sec_d = ~tog_sec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      tog_all <= 1'b0;
      tog_sec <= 1'b0;
    end else begin
      stb_q   <= rd_stb;
      tog_all <= tog_all_d;
      tog_sec <= tog_sec_d;
    end
  end
endmodule

// File: rtl/fsg_hold_timer.sv
module fsg_hold_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = start | active;

  always_comb begin
    if (start) cnt_d = LOAD;
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fsg_fail_latch.sv
module fsg_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic fail_q
);
  logic fail_d;

  always_comb begin
    fail_d = fail_q;
    if (clr) fail_d = 1'b0;
    if (set) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int AW             = 19,
  parameter int NSEC           = 8,
  parameter int PROT_PROG_CYC  = 400,
  parameter int PROT_ERASE_CYC = 20000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [AW-1:0]   rd_addr,
  input  logic [7:0]      array_data,
  input  logic            prog_busy,
  input  logic            erase_busy,
  input  logic            erase_window,
  input  logic            erase_susp,
  input  logic [7:0]      prog_datum,
  input  logic [NSEC-1:0] sector_mask,
  input  logic            limit_exceeded,
  input  logic            reset_cmd,
  input  logic            prot_prog_start,
  input  logic            prot_erase_start,
  output logic [7:0]      rd_data
);
  localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1;

  logic             rst_sync_n;
  logic             pp_act, pe_act;
  logic             prog_act, erase_act;
  logic             in_sel;
  logic             adv_all, adv_sec;
  logic             stb_rise, tog_all, tog_sec;
  logic             fail_q;
  logic [SEC_W-1:0] sec_idx;
  view_e            view;
  stat_byte_t       stat;

  fsg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  fsg_hold_timer #(.CYCLES(PROT_PROG_CYC)) i_pp_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(prot_prog_start), .active(pp_act)
  );

  fsg_hold_timer #(.CYCLES(PROT_ERASE_CYC)) i_pe_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(prot_erase_start), .active(pe_act)
  );

  fsg_fail_latch i_fail (
    .clk(clk), .rst_n(rst_sync_n), .set(limit_exceeded), .clr(reset_cmd),
    .fail_q(fail_q)
  );

  // Sector decode: a single sector uses no address bits.
  generate
    if (NSEC > 1) begin : g_multi_sec
      assign sec_idx = rd_addr[AW-1 -: SEC_W];
    end else begin : g_one_sec
      logic unused_addr;
      assign unused_addr = ^rd_addr;
      assign sec_idx     = 1'b0;
    end
  endgenerate

  assign in_sel    = sector_mask[sec_idx];
  assign prog_act  = prog_busy | pp_act;
  assign erase_act = erase_busy | erase_window | pe_act;
  assign adv_all   = prog_act | erase_act;
  assign adv_sec   = ~prog_act & (erase_act | erase_susp) & in_sel;

  fsg_toggle i_toggle (
    .clk(clk), .rst_n(rst_sync_n), .rd_stb(rd_stb),
    .adv_all(adv_all), .adv_sec(adv_sec),
    .stb_rise(stb_rise), .tog_all(tog_all), .tog_sec(tog_sec)
  );

  always_comb begin
    if (prog_act)                 view = VIEW_PROG;
    else if (erase_act)           view = VIEW_ERASE;
    else if (erase_susp && in_sel) view = VIEW_SUSP;
    else                          view = VIEW_ARRAY;
  end

  always_comb begin
    stat           = '0;
    stat.tog_all   = tog_all;
    stat.tog_sec   = tog_sec;
    stat.fail      = fail_q;
    unique case (view)
      VIEW_PROG:  stat.dpoll = ~prog_datum[7];
      VIEW_ERASE: begin
        stat.dpoll     = 1'b0;
        stat.erase_tmr = erase_busy | pe_act;
      end
      VIEW_SUSP:  stat.dpoll = 1'b1;
      default:    stat.dpoll = 1'b0;
    endcase
  end

  assign rd_data = (view == VIEW_ARRAY) ? array_data : stat;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int NSEC = 8
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            stb_rise,
  input logic            in_sel,
  input logic            prog_act,
  input logic            erase_act,
  input logic            prog_busy,
  input logic            erase_busy,
  input logic            erase_window,
  input logic            erase_susp,
  input logic [7:0]      prog_datum,
  input logic            limit_exceeded,
  input logic            reset_cmd,
  input logic            fail_q,
  input logic            tog_sec,
  input logic [7:0]      rd_data,
  input logic [7:0]      array_data
);
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!prog_act && !erase_act && !erase_susp) |-> rd_data == array_data);

  p_prog_poll_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    prog_busy |-> rd_data[7] == ~prog_datum[7]);

  p_erase_poll_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (erase_busy && !prog_act) |-> !rd_data[7]);

  p_tog_flip_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stb_rise && prog_busy) |=> (!prog_act || rd_data[6] != $past(rd_data[6])));

  p_sec_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stb_rise && !in_sel) |=> $stable(tog_sec));

  p_window_tmr_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (erase_window && !erase_busy && !prog_act && erase_act) |-> !rd_data[3] || !$stable(erase_busy) || erase_act && rd_data[3] == 1'b1 && !erase_window);

  p_fail_set_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    limit_exceeded |=> fail_q);

  p_fail_clr_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reset_cmd && !limit_exceeded) |=> !fail_q);

  p_fail_keep_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fail_q && !reset_cmd) |=> fail_q);

  p_rsv_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_act || erase_act) |-> (rd_data[4] == 1'b0 && rd_data[1:0] == 2'b00));
endmodule

bind flash_status_gen fsg_checker #(.NSEC(NSEC)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .stb_rise(stb_rise), .in_sel(in_sel),
  .prog_act(prog_act), .erase_act(erase_act), .prog_busy(prog_busy),
  .erase_busy(erase_busy), .erase_window(erase_window), .erase_susp(erase_susp),
  .prog_datum(prog_datum), .limit_exceeded(limit_exceeded),
  .reset_cmd(reset_cmd), .fail_q(fail_q), .tog_sec(tog_sec),
  .rd_data(rd_data), .array_data(array_data)
);

// File: tb/test_flash_status_gen.sv
`timescale 1ns/1ps
module test_flash_status_gen;
  localparam int AW = 19, NSEC = 8, PPC = 10, PEC = 40;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rd_stb;
  logic [AW-1:0]   rd_addr;
  logic [7:0]      array_data;
  logic            prog_busy, erase_busy, erase_window, erase_susp;
  logic [7:0]      prog_datum;
  logic [NSEC-1:0] sector_mask;
  logic            limit_exceeded, reset_cmd, prot_prog_start, prot_erase_start;
  logic [7:0]      rd_data;

  int   total = 0, bad = 0;
  logic t1 = 1'b0, t2 = 1'b0, fl = 1'b0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  flash_status_gen #(.AW(AW), .NSEC(NSEC), .PROT_PROG_CYC(PPC),
                     .PROT_ERASE_CYC(PEC)) i_flash_status_gen (.*);

  function automatic logic [AW-1:0] ad(input int s);
    logic [2:0] sb3;
    sb3 = s[2:0];
    return {sb3, 16'h0123};
  endfunction

  function automatic logic [7:0] sb(input logic d7, input logic d3);
    return {d7, t1, fl, 1'b0, d3, t2, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] val);
    @(negedge clk);
    rd_addr = a;
    rd_stb  = 1'b1;
    #1 val = rd_data;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [7:0] val);
    rd_addr = a;
    #1 val = rd_data;
  endtask

  task automatic t_idle;
    array_data = 8'h5A;
    rd(ad(3), v); chk("R1 idle pass", v, 8'h5A);
    array_data = 8'hC3;
    rd(ad(6), v); chk("R1 idle pass second", v, 8'hC3);
  endtask

  task automatic t_program;
    prog_datum = 8'h80; prog_busy = 1'b1;
    rd(ad(1), v); chk("R2 R4 program poll clear", v, sb(1'b0, 1'b0)); t1 = ~t1;
    rd(ad(7), v); chk("R4 program toggle flips", v, sb(1'b0, 1'b0)); t1 = ~t1;
    prog_datum = 8'h3C;
    rd(ad(2), v); chk("R2 R11 program poll set", v, sb(1'b1, 1'b0)); t1 = ~t1;
    prog_busy = 1'b0; array_data = 8'h3C;
    rd(ad(2), v); chk("R2 done returns array", v, 8'h3C);
  endtask

  task automatic t_erase;
    sector_mask = 8'b0000_0100; erase_window = 1'b1; array_data = 8'h11;
    rd(ad(2), v); chk("R6 R5 window in sector", v, sb(1'b0, 1'b0)); t1 = ~t1; t2 = ~t2;
    rd(ad(5), v); chk("R3 R6 window other sector", v, sb(1'b0, 1'b0)); t1 = ~t1;
    rd(ad(2), v); chk("R5 sector toggle kept off-sector", v, sb(1'b0, 1'b0)); t1 = ~t1; t2 = ~t2;
    erase_window = 1'b0; erase_busy = 1'b1;
    rd(ad(5), v); chk("R6 R3 erase running", v, sb(1'b0, 1'b1)); t1 = ~t1;
    rd(ad(2), v); chk("R5 erase in sector", v, sb(1'b0, 1'b1)); t1 = ~t1; t2 = ~t2;
  endtask

  task automatic t_suspend;
    erase_busy = 1'b0; erase_susp = 1'b1; array_data = 8'h77;
    rd(ad(2), v); chk("R3 R4 suspend selected", v, sb(1'b1, 1'b0)); t2 = ~t2;
    rd(ad(2), v); chk("R4 R5 suspend hold and sector flip", v, sb(1'b1, 1'b0)); t2 = ~t2;
    rd(ad(4), v); chk("R1 R5 suspend unselected array", v, 8'h77);
    rd(ad(2), v); chk("R5 unchanged by unselected read", v, sb(1'b1, 1'b0)); t2 = ~t2;
    prog_datum = 8'hFF; prog_busy = 1'b1;
    rd(ad(2), v); chk("R10 program over suspend", v, sb(1'b0, 1'b0)); t1 = ~t1;
    rd(ad(4), v); chk("R10 R4 program in suspend any address", v, sb(1'b0, 1'b0)); t1 = ~t1;
    prog_busy = 1'b0; erase_susp = 1'b0;
  endtask

  task automatic t_fail;
    erase_busy = 1'b1; prog_datum = 8'h00;
    @(negedge clk); limit_exceeded = 1'b1;
    @(negedge clk); limit_exceeded = 1'b0; fl = 1'b1;
    peek(ad(0), v); chk("R7 fail set", v, sb(1'b0, 1'b1));
    repeat (3) @(negedge clk);
    erase_busy = 1'b0; prog_busy = 1'b1;
    peek(ad(0), v); chk("R7 fail sticky", v, sb(1'b1, 1'b0));
    reset_cmd = 1'b1;
    @(negedge clk); reset_cmd = 1'b0; fl = 1'b0;
    peek(ad(0), v); chk("R7 fail cleared", v, sb(1'b1, 1'b0));
    prog_busy = 1'b0;
  endtask

  task automatic t_prot_prog;
    prog_datum = 8'h00; array_data = 8'hA5;
    @(negedge clk); prot_prog_start = 1'b1;
    @(negedge clk); prot_prog_start = 1'b0;
    repeat (PPC-1) @(negedge clk);
    peek(ad(6), v); chk("R8 protected program last cycle", v, sb(1'b1, 1'b0));
    @(negedge clk);
    peek(ad(6), v); chk("R8 protected program over", v, 8'hA5);
  endtask

  task automatic t_prot_erase;
    sector_mask = 8'b1000_0000; array_data = 8'h5C;
    @(negedge clk); prot_erase_start = 1'b1;
    @(negedge clk); prot_erase_start = 1'b0;
    repeat (PEC-1) @(negedge clk);
    peek(ad(7), v); chk("R9 protected erase last cycle", v, sb(1'b0, 1'b1));
    @(negedge clk);
    peek(ad(7), v); chk("R9 protected erase over", v, 8'h5C);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_stb = 1'b0; rd_addr = '0; array_data = 8'h00;
    prog_busy = 1'b0; erase_busy = 1'b0; erase_window = 1'b0; erase_susp = 1'b0;
    prog_datum = 8'h00; sector_mask = '0; limit_exceeded = 1'b0; reset_cmd = 1'b0;
    prot_prog_start = 1'b0; prot_erase_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    peek(ad(0), v); chk("R1 reset state", v, 8'h00);
    t_idle;
    t_program;
    t_erase;
    t_suspend;
    t_fail;
    t_prot_prog;
    t_prot_erase;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule